// File: doc/BRIEF.md
# Display Gamma Lookup Stage

This stage sits in a display output path and corrects every pixel through a 1024-entry table. Each entry holds three 10-bit channel values. The red channel of the incoming pixel indexes the table for the red output, green for green and blue for blue. Every pixel leaves the stage exactly one clock cycle after it enters. This holds whether the table is in use or bypassed, so switching the correction on or off never moves the pixel stream in time.

A host bus has two address windows. One is the table window, where entry i sits at byte offset i*4. The other is the control window, which holds one register at offset 0. The host writes a wanted enable into the control register. That value is only staged. It reaches the pixel path only after a config-done strobe, and then only at the next start-of-frame pulse that arrives while the display is active. The table is protected while the active enable is 1: host writes to it are dropped and a sticky error bit records the attempt. Software therefore clears the enable, commits it, polls until the readback shows 0, reloads the table, and then enables it again.

Top module: `gamma_lut_top`

## Requirements
- R1: After reset, the active enable, the staged enable, the commit-pending flag and the error flag are 0, and the pixel output is 0.
- R2: A host write to control offset 0 sets the staged enable from data bit 0. The active enable, and with it the pixel output behaviour, stays unchanged. A control read returns active enable in bit 0, staged enable in bit 1, commit pending in bit 2 and the error flag in bit 3, with all other bits 0.
- R3: A config-done strobe sets commit pending. On the first start-of-frame pulse that arrives while the display-active input is 1 and commit pending is set, the staged enable is copied to the active enable and commit pending clears.
- R4: While the display-active input is 0, start-of-frame pulses do not transfer anything. The active enable keeps its old value and commit pending stays set.
- R5: While the active enable is 0, a host write to the table window at byte address i*4 stores data bits 29:0 as entry i. Red is in bits 29:20, green in bits 19:10 and blue in bits 9:0. A read of that address returns the entry with hostRdValid high one cycle after the read request. Accesses whose two low address bits are not zero are ignored.
- R6: While the active enable is 1, host writes to the table window leave the table unchanged and set the error flag. The error flag stays set until a control write with data bit 3 set clears it.
- R7: With the active enable at 1, each output channel equals the matching channel field of the entry indexed by that channel's input value, one cycle after the input.
- R8: With the active enable at 0, the pixel output equals the pixel input of the previous cycle.
- R9: A config-done strobe in the same cycle as a transferring start-of-frame pulse leaves commit pending set, so the next qualifying frame start performs another transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel and host clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write request |
| hostRdEn | input | 1 | Host read request |
| hostLutSel | input | 1 | 1 selects the table window, 0 the control window |
| hostAddr | input | 12 | Byte address within the selected window |
| hostWrData | input | 30 | Host write data |
| hostRdData | output | 30 | Host read data, valid with hostRdValid |
| hostRdValid | output | 1 | High one cycle after a read request |
| cfgDone | input | 1 | Config-done commit strobe |
| frameStart | input | 1 | Start-of-frame pulse |
| dispActive | input | 1 | Display output active |
| pixIn | input | 30 | Input pixel {red, green, blue} |
| pixOut | output | 30 | Output pixel, one cycle after input |

## Verification
The bench first fills the whole table with distinct per-channel values. This means a lookup that takes a field from the wrong entry, or from the wrong channel's slice, shows a value that cannot match. It issues a commit while the display is idle, where a design that ignores the display-active gate would switch the table on early. It then issues a config-done in the same cycle as a frame start, where a design that clears pending last would lose the second commit. Writes made while the table is enabled are checked by reading the entry back and by reading the error bit. A design without the write lock would show the new data there, and one without the sticky flag would read 0 for the error.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
  // control readback bit positions
  localparam int RB_ACTIVE  = 0;
  localparam int RB_SHADOW  = 1;
  localparam int RB_PENDING = 2;
  localparam int RB_ERROR   = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic lutWrite;
    logic lutRead;
    logic lutEnable;
  } lutCtrl_t;
endpackage

// File: rtl/gamma_lut_ctrl.sv
module gamma_lut_ctrl
  import gamma_lut_pkg::*;
#(
  parameter int IDXW = 10,
  parameter int RDW  = 30
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrReq,
  input  logic            rdReq,
  input  logic            lutSel,
  input  logic [IDXW-1:0] regIdx,
  input  logic            wrEnableBit,
  input  logic            wrClearBit,
  input  logic            cfgDone,
  input  logic            frameStart,
  input  logic            dispActive,
  output lutCtrl_t        ctrlBus,
  output logic            activeEn,
  output logic            commitPending,
  output logic            errFlag,
  output logic [RDW-1:0]  ctrlRdData,
  output logic            rdLutQ,
  output logic            rdValidQ
);
  logic shadowEn;
  logic ctrlWrHit;
  logic ctrlRdHit;
  logic transfer;
  logic lockedWrite;

  assign ctrlWrHit   = wrReq & ~lutSel & (regIdx == '0);
  assign ctrlRdHit   = rdReq & ~lutSel & (regIdx == '0);
  assign transfer    = commitPending & frameStart & dispActive;
  assign lockedWrite = wrReq & lutSel & activeEn;

  assign ctrlBus.lutWrite  = wrReq & lutSel & ~activeEn;
  assign ctrlBus.lutRead   = rdReq & lutSel;
  assign ctrlBus.lutEnable = activeEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowEn      <= 1'b0;
      activeEn      <= 1'b0;
      commitPending <= 1'b0;
      errFlag       <= 1'b0;
    end else begin
      if (ctrlWrHit) shadowEn <= wrEnableBit;
      if (transfer)  activeEn <= shadowEn;
      commitPending <= cfgDone | (commitPending & ~transfer);
      errFlag       <= lockedWrite | (errFlag & ~(ctrlWrHit & wrClearBit));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlRdData <= '0;
      rdLutQ     <= 1'b0;
      rdValidQ   <= 1'b0;
    end else begin
      rdValidQ <= rdReq;
      rdLutQ   <= lutSel;
      ctrlRdData <= '0;
      if (ctrlRdHit) begin
        ctrlRdData[RB_ACTIVE]  <= activeEn;
        ctrlRdData[RB_SHADOW]  <= shadowEn;
        ctrlRdData[RB_PENDING] <= commitPending;
        ctrlRdData[RB_ERROR]   <= errFlag;
      end
    end
  end
endmodule

// File: rtl/gamma_lut_datapath.sv
module gamma_lut_datapath
  import gamma_lut_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  lutCtrl_t        ctrlBus,
  input  logic [CW-1:0]   lutIdx,
  input  logic [3*CW-1:0] lutWrData,
  input  logic [3*CW-1:0] pixIn,
  output logic [3*CW-1:0] pixOut,
  output logic [3*CW-1:0] lutRdData
);
  localparam int ENTRIES = 1 << CW;
  localparam int PIXW    = 3 * CW;

  logic [PIXW-1:0] table_q [ENTRIES];
  logic [PIXW-1:0] mapped;

  always_ff @(posedge clk) begin
    if (ctrlBus.lutWrite) table_q[lutIdx] <= lutWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) lutRdData <= '0;
    else if (ctrlBus.lutRead) lutRdData <= table_q[lutIdx];
  end

  // channel 0 = blue, 1 = green, 2 = red; each indexes its own field
  for (genvar ch = 0; ch < 3; ch++) begin : g_chan
    logic [CW-1:0]   chIdx;
    logic [PIXW-1:0] chEntry;
    assign chIdx   = pixIn[ch*CW +: CW];
    assign chEntry = table_q[chIdx];
    assign mapped[ch*CW +: CW] = chEntry[ch*CW +: CW];
  end

  always_ff @(posedge clk) begin
    if (!rstN) pixOut <= '0;
    else       pixOut <= ctrlBus.lutEnable ? mapped : pixIn;
  end
endmodule

// File: rtl/gamma_lut_top.sv
module gamma_lut_top
  import gamma_lut_pkg::*;
#(
  parameter int CW = 10,
  localparam int PIXW    = 3 * CW,
  localparam int HOST_AW = CW + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWrEn,
  input  logic               hostRdEn,
  input  logic               hostLutSel,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [PIXW-1:0]    hostWrData,
  output logic [PIXW-1:0]    hostRdData,
  output logic               hostRdValid,
  input  logic               cfgDone,
  input  logic               frameStart,
  input  logic               dispActive,
  input  logic [PIXW-1:0]    pixIn,
  output logic [PIXW-1:0]    pixOut
);
  lutCtrl_t        ctrlBus;
  logic            activeEn;
  logic            commitPending;
  logic            errFlag;
  logic            aligned;
  logic            wrReq;
  logic            rdReq;
  logic            rdLutQ;
  logic [PIXW-1:0] ctrlRdData;
  logic [PIXW-1:0] lutRdData;
  logic [CW-1:0]   wordIdx;

  assign aligned = (hostAddr[1:0] == 2'b00);
  assign wrReq   = hostWrEn & aligned;
  assign rdReq   = hostRdEn & aligned;
  assign wordIdx = hostAddr[HOST_AW-1:2];

  gamma_lut_ctrl #(.IDXW(CW), .RDW(PIXW)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .wrReq        (wrReq),
    .rdReq        (rdReq),
    .lutSel       (hostLutSel),
    .regIdx       (wordIdx),
    .wrEnableBit  (hostWrData[RB_ACTIVE]),
    .wrClearBit   (hostWrData[RB_ERROR]),
    .cfgDone      (cfgDone),
    .frameStart   (frameStart),
    .dispActive   (dispActive),
    .ctrlBus      (ctrlBus),
    .activeEn     (activeEn),
    .commitPending(commitPending),
    .errFlag      (errFlag),
    .ctrlRdData   (ctrlRdData),
    .rdLutQ       (rdLutQ),
    .rdValidQ     (hostRdValid)
  );

  gamma_lut_datapath #(.CW(CW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlBus  (ctrlBus),
    .lutIdx   (wordIdx),
    .lutWrData(hostWrData),
    .pixIn    (pixIn),
    .pixOut   (pixOut),
    .lutRdData(lutRdData)
  );

  assign hostRdData = rdLutQ ? lutRdData : ctrlRdData;
endmodule

// File: rtl/gamma_lut_chk.sv
module gamma_lut_chk #(
  parameter int CW = 10,
  localparam int PIXW = 3 * CW
) (
  input logic            clk,
  input logic            rstN,
  input logic            wrReq,
  input logic            rdReq,
  input logic            hostLutSel,
  input logic            hostRdValid,
  input logic            cfgDone,
  input logic            frameStart,
  input logic            dispActive,
  input logic            activeEn,
  input logic            commitPending,
  input logic            errFlag,
  input logic [PIXW-1:0] pixIn,
  input logic [PIXW-1:0] pixOut
);
  // R3
  commit_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && !$stable(activeEn) |-> $past(frameStart && dispActive && commitPending));

  // R3
  pend_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgDone |=> commitPending);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dispActive |=> $stable(activeEn) && commitPending == $past(commitPending | cfgDone));

  // R6
  lock_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrReq && hostLutSel && activeEn |=> errFlag);

  // R8
  bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && !$past(activeEn) |-> pixOut == $past(pixIn));

  // R5
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> hostRdValid);
endmodule

bind gamma_lut_top gamma_lut_chk #(.CW(CW)) u_chk (.*);

// File: tb/sim_gamma_lut_top.sv
module sim_gamma_lut_top;
  localparam int CW   = 10;
  localparam int PIXW = 3 * CW;
  localparam int N    = 1 << CW;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            hostWrEn = 1'b0, hostRdEn = 1'b0, hostLutSel = 1'b0;
  logic [CW+1:0]   hostAddr = '0;
  logic [PIXW-1:0] hostWrData = '0;
  logic [PIXW-1:0] hostRdData;
  logic            hostRdValid;
  logic            cfgDone = 1'b0, frameStart = 1'b0, dispActive = 1'b0;
  logic [PIXW-1:0] pixIn = '0;
  logic [PIXW-1:0] pixOut;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  gamma_lut_top #(.CW(CW)) u0 (.*);

  function automatic logic [PIXW-1:0] entryVal(int i);
    logic [CW-1:0] r, g, b;
    r = CW'(i) ^ {CW{1'b1}};
    g = CW'(i * 3);
    b = CW'(i + 5);
    return {r, g, b};
  endfunction

  function automatic logic [PIXW-1:0] lookVal(logic [PIXW-1:0] p);
    logic [PIXW-1:0] er, eg, eb;
    er = entryVal(int'(p[29:20]));
    eg = entryVal(int'(p[19:10]));
    eb = entryVal(int'(p[9:0]));
    return {er[29:20], eg[19:10], eb[9:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hostWrite(logic lut, int addr, logic [PIXW-1:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostLutSel = lut; hostAddr = (CW+2)'(addr); hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(logic lut, int addr, output logic [PIXW-1:0] d, output logic v);
    @(negedge clk);
    hostRdEn = 1'b1; hostLutSel = lut; hostAddr = (CW+2)'(addr);
    @(negedge clk);
    hostRdEn = 1'b0;
    d = hostRdData; v = hostRdValid;
  endtask

  task automatic strobe(logic cd, logic fs);
    @(negedge clk);
    cfgDone = cd; frameStart = fs;
    @(negedge clk);
    cfgDone = 1'b0; frameStart = 1'b0;
  endtask

  task automatic ctrlExpect(string req, logic [3:0] exp);
    logic [PIXW-1:0] d; logic v;
    hostRead(1'b0, 0, d, v);
    chk({req, " valid"}, 32'(v), 32'd1);
    chk({req, " ctrl"}, 32'(d), 32'(exp));
  endtask

  task automatic pixExpect(string req, logic [PIXW-1:0] p, logic [PIXW-1:0] exp);
    @(negedge clk);
    pixIn = p;
    @(negedge clk);
    chk(req, 32'(pixOut), 32'(exp));
  endtask

  task automatic testReset();   // R1
    chk("R1 pixOut", 32'(pixOut), 32'd0);
    ctrlExpect("R1", 4'h0);
  endtask

  task automatic testFill();    // R5
    logic [PIXW-1:0] d; logic v;
    for (int i = 0; i < N; i++) hostWrite(1'b1, i * 4, entryVal(i));
    hostRead(1'b1, 0, d, v);
    chk("R5 valid", 32'(v), 32'd1);
    chk("R5 entry0", 32'(d), 32'(entryVal(0)));
    hostRead(1'b1, 1023 * 4, d, v);
    chk("R5 entry1023", 32'(d), 32'(entryVal(1023)));
    hostWrite(1'b1, 517 * 4 + 2, 30'h1234567);  // misaligned: ignored
    hostRead(1'b1, 517 * 4, d, v);
    chk("R5 misaligned ignored", 32'(d), 32'(entryVal(517)));
  endtask

  task automatic testBypass();  // R8
    pixExpect("R8 bypass a", 30'h0ABCDEF1, 30'h0ABCDEF1);
    pixExpect("R8 bypass b", 30'h3FFFFFFF, 30'h3FFFFFFF);
  endtask

  task automatic testShadow();  // R2
    hostWrite(1'b0, 0, 30'h1);
    ctrlExpect("R2 staged only", 4'h2);
    pixExpect("R2 still bypass", 30'h00300C03, 30'h00300C03);
  endtask

  task automatic testIdleCommit(); // R4
    dispActive = 1'b0;
    strobe(1'b1, 1'b0);
    strobe(1'b0, 1'b1);
    ctrlExpect("R4 idle no transfer", 4'h6);
    pixExpect("R4 still bypass", 30'h00100401, 30'h00100401);
  endtask

  task automatic testCommit();  // R3 R9
    dispActive = 1'b1;
    strobe(1'b1, 1'b1);
    ctrlExpect("R9 pending kept", 4'h7);
    strobe(1'b0, 1'b1);
    ctrlExpect("R3 pending cleared", 4'h3);
  endtask

  task automatic testLookup();  // R7
    pixExpect("R7 lookup a", 30'h00000000, lookVal(30'h00000000));
    pixExpect("R7 lookup b", {10'd7, 10'd900, 10'd1023}, lookVal({10'd7, 10'd900, 10'd1023}));
    pixExpect("R7 lookup c", {10'd1023, 10'd1, 10'd512}, lookVal({10'd1023, 10'd1, 10'd512}));
  endtask

  task automatic testLocked();  // R6
    logic [PIXW-1:0] d; logic v;
    hostWrite(1'b1, 5 * 4, 30'h15555555);
    hostRead(1'b1, 5 * 4, d, v);
    chk("R6 table unchanged", 32'(d), 32'(entryVal(5)));
    pixExpect("R6 lookup unchanged", {10'd5, 10'd5, 10'd5}, lookVal({10'd5, 10'd5, 10'd5}));
    ctrlExpect("R6 error set", 4'hB);
    ctrlExpect("R6 error sticky", 4'hB);
    hostWrite(1'b0, 0, 30'h9);
    ctrlExpect("R6 error cleared", 4'h3);
  endtask

  task automatic testDisable(); // R3 R5 R8
    logic [PIXW-1:0] d; logic v;
    hostWrite(1'b0, 0, 30'h0);
    strobe(1'b1, 1'b0);
    strobe(1'b0, 1'b1);
    ctrlExpect("R3 disabled", 4'h0);
    pixExpect("R8 bypass again", {10'd5, 10'd5, 10'd5}, {10'd5, 10'd5, 10'd5});
    hostWrite(1'b1, 5 * 4, 30'h15555555);
    hostRead(1'b1, 5 * 4, d, v);
    chk("R5 rewrite accepted", 32'(d), 32'h15555555);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testFill();
    testBypass();
    testShadow();
    testIdleCommit();
    testCommit();
    testLookup();
    testLocked();
    testDisable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule